// File: doc/BRIEF.md
# Virtual Debug Hub with Enumerable Node Table

This block sits behind a device-level TAP controller and shares one physical scan port among several debug nodes. It does not run the TAP state machine. It receives the decoded device instruction and the capture, shift and update data-register strobes, all in the test-clock domain. The clock `clk` is that test clock. A synchronous reset `rst` stands for Test-Logic-Reset.

Two device instructions are used. Under the select-chain instruction (code 0x0E), the data register is a hub chain of `ADDR_W + M_W` bits. The upper `ADDR_W` bits hold a node address and the lower `M_W` bits hold a virtual instruction. `ADDR_W` is ceil(log2(NODES+1)). Under the data-path instruction (code 0x0C), what is scanned depends on the latched address and virtual instruction:
- Address 0 with virtual instruction 0 gives a 4-bit readout register. Software reads the hub description word through it, then one identity word per node, one nibble per scan.
- A valid nonzero address sends the scan to that one node.

A node's address is its position in that readout: the first node word belongs to address 1.

Top module: `vhub_top`

## Requirements
- R1: After reset, the latched address and virtual instruction are 0 and no node strobe or load pulse is active. The first readout nibble is nibble 0 of the hub word.
- R2: Under device instruction 0x0E, capture loads the chain with {address, virtual instruction}. Each shift moves the chain one bit toward bit 0, with `tdi` entering the MSB and `tdo` showing bit 0. Update latches the upper `ADDR_W` bits as the address and the lower `M_W` bits as the virtual instruction.
- R3: The hub word has this layout: [31:27] hub version, [26:19] NODES, [18:8] manufacturer code 0x06E, [7:0] M_W.
- R4: Under instruction 0x0C with address 0 and virtual instruction 0, capture loads the current 4-bit nibble and `tdo` presents it LSB first. Each update advances to the next nibble. Words are sent least significant nibble first, and 8 nibbles make one word.
- R5: After the hub word come NODES node words, node k at position k+1 (address k+1). Each node word has this layout: [31:27] version, [26:19] node ID, [18:8] manufacturer, [7:0] instance. After the last node word the readout wraps back to the hub word.
- R6: A capture of the 0x0E chain returns the readout to nibble 0 of the hub word, even in the middle of a word.
- R7: Under 0x0C with an address from 1 to NODES, the capture, shift and update strobes go only to node (address-1). `tdo` is that node's `node_tdo` bit.
- R8: An update of the 0x0E chain with an address from 1 to NODES pulses `node_vir_load` for that node only, for one cycle after the update edge. `node_vir` then carries the new virtual instruction. An update with address 0 pulses no node.
- R9: Strobes under any other device instruction change neither the chain, the latched selection nor any node output.
- R10: Under 0x0C, an address above NODES, or address 0 with a nonzero virtual instruction, drives no node strobe and holds `tdo` at 0. An update of the 0x0E chain with an address above NODES pulses no node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (Test-Logic-Reset) |
| ir_code | input | IR_W | Current device instruction |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| node_tdo | input | NODES | Serial data from each node |
| node_capture | output | NODES | Per-node capture strobe |
| node_shift | output | NODES | Per-node shift strobe |
| node_update | output | NODES | Per-node update strobe |
| node_vir_load | output | NODES | One-cycle pulse: new virtual instruction for the node |
| node_vir | output | M_W | Latched virtual instruction, zero-padded |

## Verification
The hardest state to reach is a readout pointer in the middle of a word, followed by a restart. Reaching it takes many full nibble scans under the data instruction. The bench reads the hub word and all node words, checks the wrap, then stops after three nibbles. It then issues a chain scan and reads the hub word again from the start. Readback of the chain through its own capture shows that strobes under a foreign instruction leave the latched selection unchanged.

// File: rtl/vhub_pkg.sv
package vhub_pkg;
  localparam logic [10:0] HUB_MFG = 11'h06E;

  function automatic int addr_bits(input int nodes);
    return $clog2(nodes + 1);
  endfunction

  function automatic logic [31:0] info_word(input logic [4:0] ver, input logic [7:0] id,
                                            input logic [10:0] mfg, input logic [7:0] low);
    return {ver, id, mfg, low};
  endfunction
endpackage

// File: rtl/vhub_vir_chain.sv
module vhub_vir_chain #(
  parameter int NODES  = 4,
  parameter int ADDR_W = 3,
  parameter int M_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] addr_q,
  output logic [M_W-1:0]    vir_q,
  output logic [NODES-1:0]  load_q
);
  localparam int W = ADDR_W + M_W;
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      addr_q <= '0;
      vir_q  <= '0;
      load_q <= '0;
    end else begin
      load_q <= '0;
      if (sel && capture)    sr <= {addr_q, vir_q};
      else if (sel && shift) sr <= {tdi, sr[W-1:1]};
      if (sel && update) begin
        addr_q <= sr[W-1:M_W];
        vir_q  <= sr[M_W-1:0];
        for (int i = 0; i < NODES; i++)
          if (sr[W-1:M_W] == ADDR_W'(i + 1)) load_q[i] <= 1'b1;
      end
    end
  end

  assign tdo = sr[0];

  // R2
  addr_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && update) |=> (addr_q == $past(sr[W-1:M_W]) && vir_q == $past(sr[M_W-1:0])));
  // R8
  hub_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && update && sr[W-1:M_W] == '0) |=> (load_q == '0));
endmodule

// File: rtl/vhub_info_reader.sv
module vhub_info_reader
  import vhub_pkg::*;
#(
  parameter int                 NODES     = 4,
  parameter int                 ADDR_W    = 3,
  parameter int                 M_W       = 4,
  parameter logic [4:0]         HUB_VER   = 5'd1,
  parameter logic [NODES*5-1:0] NODE_VER  = '0,
  parameter logic [NODES*8-1:0] NODE_ID   = '0,
  parameter logic [NODES*8-1:0] NODE_INST = '0,
  parameter logic [10:0]        NODE_MFG  = 11'h06E
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic tdi,
  output logic tdo
);
  logic [31:0]       words [0:NODES];
  logic [ADDR_W-1:0] word_idx;
  logic [2:0]        nib_idx;
  logic [3:0]        nsr;
  logic [3:0]        cur_nib;

  assign words[0] = info_word(HUB_VER, 8'(NODES), HUB_MFG, 8'(M_W));
  for (genvar g = 0; g < NODES; g++) begin : g_node_word
    assign words[g+1] = info_word(NODE_VER[g*5 +: 5], NODE_ID[g*8 +: 8],
                                  NODE_MFG, NODE_INST[g*8 +: 8]);
  end

  assign cur_nib = words[word_idx][{nib_idx, 2'b00} +: 4];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      word_idx <= '0;
      nib_idx  <= '0;
      nsr      <= '0;
    end else begin
      if (sel && capture)    nsr <= cur_nib;
      else if (sel && shift) nsr <= {tdi, nsr[3:1]};
      if (sel && update) begin
        nib_idx <= nib_idx + 3'd1;
        if (nib_idx == 3'd7)
          word_idx <= (word_idx == ADDR_W'(NODES)) ? '0 : word_idx + 1'b1;
      end
    end
  end

  assign tdo = nsr[0];

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (word_idx == '0 && nib_idx == 3'd0));
  // R4
  nibble_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && update && !restart) |=> (nib_idx == $past(nib_idx) + 3'd1));
endmodule

// File: rtl/vhub_top.sv
module vhub_top
  import vhub_pkg::*;
#(
  parameter int                 IR_W      = 10,
  parameter logic [IR_W-1:0]    IR_CHAIN  = 10'h00E,
  parameter logic [IR_W-1:0]    IR_DATA   = 10'h00C,
  parameter int                 NODES     = 4,
  parameter int                 M_W       = 4,
  parameter logic [4:0]         HUB_VER   = 5'd1,
  parameter logic [NODES*5-1:0] NODE_VER  = {5'd1, 5'd2, 5'd3, 5'd4},
  parameter logic [NODES*8-1:0] NODE_ID   = {8'h30, 8'h08, 8'h21, 8'h08},
  parameter logic [NODES*8-1:0] NODE_INST = {8'h03, 8'h02, 8'h01, 8'h00},
  parameter logic [10:0]        NODE_MFG  = 11'h06E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [NODES-1:0] node_tdo,
  output logic [NODES-1:0] node_capture,
  output logic [NODES-1:0] node_shift,
  output logic [NODES-1:0] node_update,
  output logic [NODES-1:0] node_vir_load,
  output logic [M_W-1:0]   node_vir
);
  localparam int ADDR_W = addr_bits(NODES);

  logic              is_chain, is_data, info_sel;
  logic              chain_tdo, info_tdo, node_hit, hit_tdo;
  logic [ADDR_W-1:0] addr_q;
  logic [M_W-1:0]    vir_q;

  assign is_chain = (ir_code == IR_CHAIN);
  assign is_data  = (ir_code == IR_DATA);
  assign info_sel = is_data && addr_q == '0 && vir_q == '0;

  vhub_vir_chain #(.NODES(NODES), .ADDR_W(ADDR_W), .M_W(M_W)) u_chain (
    .clk(clk), .rst(rst), .sel(is_chain), .capture(capture_dr), .shift(shift_dr),
    .update(update_dr), .tdi(tdi), .tdo(chain_tdo), .addr_q(addr_q), .vir_q(vir_q),
    .load_q(node_vir_load));

  vhub_info_reader #(.NODES(NODES), .ADDR_W(ADDR_W), .M_W(M_W), .HUB_VER(HUB_VER),
    .NODE_VER(NODE_VER), .NODE_ID(NODE_ID), .NODE_INST(NODE_INST), .NODE_MFG(NODE_MFG)) u_info (
    .clk(clk), .rst(rst), .restart(is_chain && capture_dr), .sel(info_sel),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi), .tdo(info_tdo));

  always_comb begin
    node_hit     = 1'b0;
    hit_tdo      = 1'b0;
    node_capture = '0;
    node_shift   = '0;
    node_update  = '0;
    for (int i = 0; i < NODES; i++) begin
      if (is_data && addr_q == ADDR_W'(i + 1)) begin
        node_hit        = 1'b1;
        hit_tdo         = node_tdo[i];
        node_capture[i] = capture_dr;
        node_shift[i]   = shift_dr;
        node_update[i]  = update_dr;
      end
    end
  end

  assign tdo      = is_chain ? chain_tdo : info_sel ? info_tdo : node_hit ? hit_tdo : 1'b0;
  assign node_vir = vir_q;

  // R7
  one_node_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(node_shift) && $onehot0(node_capture) && $onehot0(node_update));
  // R8
  one_load_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(node_vir_load));
  // R9
  foreign_ir_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_chain) |=> ($stable(addr_q) && $stable(vir_q)));
endmodule

// File: tb/tb_vhub_top.sv
module tb_vhub_top;
  localparam logic [9:0] CHAIN = 10'h00E;
  localparam logic [9:0] DATA  = 10'h00C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] ir_code = '0;
  logic       capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic       tdo;
  logic [3:0] node_tdo = '0;
  logic [3:0] node_capture, node_shift, node_update, node_vir_load;
  logic [3:0] node_vir;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vhub_top dut (
    .clk(clk), .rst(rst), .ir_code(ir_code), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .node_tdo(node_tdo),
    .node_capture(node_capture), .node_shift(node_shift), .node_update(node_update),
    .node_vir_load(node_vir_load), .node_vir(node_vir));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] node_word(input int k);
    logic [4:0] ver [4] = '{5'd4, 5'd3, 5'd2, 5'd1};
    logic [7:0] id  [4] = '{8'h08, 8'h21, 8'h08, 8'h30};
    return {ver[k], id[k], 11'h06E, 8'(k)};
  endfunction

  localparam logic [31:0] HUB_WORD = {5'd1, 8'd4, 11'h06E, 8'd4};

  // Full chain scan; returns the captured old value and the load pulse seen after update.
  task automatic vir_scan(input logic [6:0] val, output logic [6:0] old, output logic [3:0] load);
    ir_code = CHAIN;
    capture_dr = 1; @(negedge clk); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < 7; i++) begin
      old[i] = tdo; tdi = val[i]; @(negedge clk);
    end
    shift_dr = 0; update_dr = 1; tdi = 0; @(negedge clk);
    update_dr = 0; load = node_vir_load;
    @(negedge clk);
  endtask

  task automatic read_nibble(output logic [3:0] nib);
    ir_code = DATA;
    capture_dr = 1; @(negedge clk); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < 4; i++) begin
      nib[i] = tdo; @(negedge clk);
    end
    shift_dr = 0; update_dr = 1; @(negedge clk); update_dr = 0;
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [3:0] n;
    w = '0;
    for (int k = 0; k < 8; k++) begin
      read_nibble(n); w[k*4 +: 4] = n;
    end
  endtask

  task automatic t_reset();
    logic [3:0] n, ld; logic [6:0] old;
    chk("R1 node strobes after reset", {node_capture, node_shift, node_update, node_vir_load}, '0);
    read_nibble(n);
    chk("R1 first nibble is hub nibble 0", n, HUB_WORD[3:0]);
    vir_scan(7'h00, old, ld);
    chk("R1 R2 reset selection readback", old, 7'h00);
  endtask

  task automatic t_readout();
    logic [31:0] w; logic [3:0] n, ld; logic [6:0] old;
    read_word(w); chk("R3 R4 hub word", w, HUB_WORD);
    for (int k = 0; k < 4; k++) begin
      read_word(w); chk($sformatf("R5 node word %0d", k), w, node_word(k));
    end
    read_word(w); chk("R5 wrap to hub word", w, HUB_WORD);
    for (int k = 0; k < 3; k++) read_nibble(n);
    vir_scan(7'h00, old, ld);
    read_word(w); chk("R6 restart mid-word", w, HUB_WORD);
  endtask

  task automatic t_select();
    logic [3:0] ld; logic [6:0] old;
    vir_scan({3'd2, 4'hA}, old, ld);
    chk("R8 load pulse for node 2", ld, 4'b0010);
    chk("R8 node_vir value", node_vir, 4'hA);
    chk("R8 load is one cycle", node_vir_load, 4'b0000);
    vir_scan({3'd3, 4'h5}, old, ld);
    chk("R2 chain readback", old, {3'd2, 4'hA});
    ir_code = DATA; node_tdo = 4'b0100; #1;
    chk("R7 tdo from node 3", tdo, 1'b1);
    node_tdo = 4'b1011; #1;
    chk("R7 tdo ignores other nodes", tdo, 1'b0);
    shift_dr = 1; #1;
    chk("R7 shift to node 3 only", node_shift, 4'b0100);
    shift_dr = 0; capture_dr = 1; update_dr = 1; #1;
    chk("R7 capture/update to node 3", {node_capture, node_update}, 8'b0100_0100);
    capture_dr = 0; update_dr = 0; node_tdo = '0;
    @(negedge clk);
    vir_scan({3'd0, 4'h0}, old, ld);
    chk("R8 hub address pulses nothing", ld, 4'b0000);
  endtask

  task automatic t_foreign_ir();
    logic [3:0] ld; logic [6:0] old;
    vir_scan({3'd1, 4'h6}, old, ld);
    ir_code = 10'h3FF; tdi = 1;
    capture_dr = 1; @(negedge clk); capture_dr = 0; shift_dr = 1;
    repeat (7) @(negedge clk);
    shift_dr = 0; update_dr = 1; #1;
    chk("R9 no node strobe under foreign IR", {node_capture, node_shift, node_update}, '0);
    @(negedge clk); update_dr = 0; tdi = 0;
    chk("R9 no load under foreign IR", node_vir_load, '0);
    vir_scan({3'd1, 4'h6}, old, ld);
    chk("R9 selection unchanged", old, {3'd1, 4'h6});
  endtask

  task automatic t_out_of_range();
    logic [3:0] ld; logic [6:0] old;
    vir_scan({3'd6, 4'h1}, old, ld);
    chk("R10 no load for address 6", ld, 4'b0000);
    ir_code = DATA; node_tdo = 4'hF; shift_dr = 1; capture_dr = 1; #1;
    chk("R10 no strobes for address 6", {node_capture, node_shift}, '0);
    chk("R10 tdo low for address 6", tdo, 1'b0);
    shift_dr = 0; capture_dr = 0; @(negedge clk);
    vir_scan({3'd0, 4'h3}, old, ld);
    ir_code = DATA; capture_dr = 1; @(negedge clk); capture_dr = 0;
    chk("R10 tdo low for hub with nonzero VIR", tdo, 1'b0);
    node_tdo = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_readout();
    t_select();
    t_foreign_ir();
    t_out_of_range();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule